// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides its input clock by a programmable 18-bit ratio N and gives one output pulse per N input cycles. Internally a 7-bit prescaler counts either 64 or 65 input cycles, depending on a modulus-control signal. Two down-counters steer it. The swallow counter is loaded with A, the low 6 bits of N. The main counter is loaded with B, the upper 12 bits of N. The prescaler runs at divide-by-65 until the swallow counter is empty and at divide-by-64 for the rest of the B prescaler cycles. The period is therefore 65·A + 64·(B − A) = 64·B + A input cycles.

The divisor is sampled on the clock edge that ends a period. A value written in the middle of a period takes effect only in the next one. A standby input clears and stops every counter. On leaving standby, or after reset, the first enabled edge arms the block and loads the counters. The first pulse then follows N cycles later. A combinational flag reports ratios whose main part is smaller than their swallow part. For such ratios the output period is not defined.

Top module: `swallow_divider`

## Requirements
- R1: While reset is asserted, div_pulse, mod_sel and all internal counters are zero, and no pulse appears until reset is released.
- R2: With a valid ratio N, div_pulse is high for exactly one clock cycle and repeats every N clock cycles.
- R3: Within each period, mod_sel is high for exactly the first 65·A cycles and low for the rest, where A = ratio[5:0]. When A = 0 it is never high. When B = A it is high for the whole period, where B = ratio[17:6].
- R4: A ratio of 10000 decodes to B = 156 and A = 16. It gives pulses 10000 cycles apart, with mod_sel high for 1040 cycles of each period.
- R5: The smallest continuous ratio, 4032 (B = 63, A = 0), gives pulses 4032 cycles apart.
- R6: ratio_bad is high exactly when ratio[17:6] < ratio[5:0]. It follows the ratio input combinationally, also during standby.
- R7: A ratio applied in the middle of a period does not change that period. It sets the length of the next period, because the ratio is sampled on the edge that raises div_pulse.
- R8: While standby is high, the counters are cleared and div_pulse and mod_sel are low. After standby falls, one edge arms the block and the first pulse is visible N + 1 cycles after the release.
- R9: After reset is released, the first enabled edge arms the block, and the first pulse appears after the N edges that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Stops and clears all counters while high |
| ratio | input | 18 | Divisor N; bits 17:6 are B, bits 5:0 are A |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| mod_sel | output | 1 | Prescaler modulus: 1 = divide by 65, 0 = divide by 64 |
| ratio_bad | output | 1 | High when B < A in the applied ratio |

## Verification
The bench targets ratio edges at which a swallow design tends to fail. With A = 0, a counter that mis-handles an empty swallow count spends one prescaler cycle at 65 and adds a cycle to every period. With B = A, an off-by-one in the handover to divide-by-64 shows up as a 4094- or 4096-cycle mod_sel window. A ratio change in the middle of a period exposes a design that reloads immediately, because the period then has the wrong length. Standby applied in the middle of a period, followed by release, exposes a design that resumes a stale count instead of restarting one full N + 1 cycles after release.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int A_W = 6,
  parameter int B_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               standby,
  input  logic [A_W+B_W-1:0] ratio,
  output logic               div_pulse,
  output logic               mod_sel,
  output logic               ratio_bad
);
  localparam int N_W  = A_W + B_W;
  localparam int P    = 1 << A_W;
  localparam int PC_W = A_W + 1;

  logic [PC_W-1:0] pre_cnt;
  logic [A_W-1:0]  swl_left;
  logic [B_W-1:0]  main_left;
  logic            armed;

  wire [A_W-1:0] new_a = ratio[A_W-1:0];
  wire [B_W-1:0] new_b = ratio[N_W-1:A_W];

  assign mod_sel   = armed && (swl_left != '0);
  assign ratio_bad = new_b < B_W'(new_a);

  wire pre_end    = armed && (pre_cnt == (mod_sel ? PC_W'(P) : PC_W'(P - 1)));
  wire period_end = pre_end && (main_left == B_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      swl_left  <= '0;
      main_left <= '0;
      armed     <= 1'b0;
      div_pulse <= 1'b0;
    end else if (standby) begin
      pre_cnt   <= '0;
      swl_left  <= '0;
      main_left <= '0;
      armed     <= 1'b0;
      div_pulse <= 1'b0;
    end else if (!armed) begin
      armed     <= 1'b1;
      pre_cnt   <= '0;
      main_left <= new_b;
      swl_left  <= new_a;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= period_end;
      if (pre_end) begin
        pre_cnt <= '0;
        if (period_end) begin
          main_left <= new_b;
          swl_left  <= new_a;
        end else begin
          main_left <= main_left - B_W'(1);
          if (swl_left != '0) swl_left <= swl_left - A_W'(1);
        end
      end else begin
        pre_cnt <= pre_cnt + PC_W'(1);
      end
    end
  end

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R2
  pulse_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> armed);

  // R8
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (pre_cnt == '0 && !div_pulse && !mod_sel && !armed));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !standby && !period_end) |=>
      (main_left == $past(main_left) || main_left == $past(main_left) - B_W'(1)));
endmodule

// File: tb/swallow_divider_bench.sv
module swallow_divider_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic [17:0] ratio = 18'd10000;
  logic        div_pulse, mod_sel, ratio_bad;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  swallow_divider u_swallow_divider (
    .clk(clk), .rst_n(rst_n), .standby(standby), .ratio(ratio),
    .div_pulse(div_pulse), .mod_sel(mod_sel), .ratio_bad(ratio_bad)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural model
  bit m_armed = 0;
  int m_pos = 0;
  int m_n = 0;
  bit m_pulse = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_pos = 0; m_pulse = 0;
    end else if (standby) begin
      m_armed = 0; m_pos = 0; m_pulse = 0;
    end else if (!m_armed) begin
      m_armed = 1; m_pos = 0; m_n = int'(ratio); m_pulse = 0;
    end else begin
      m_pos++;
      if (m_pos == m_n) begin
        m_pos = 0; m_n = int'(ratio); m_pulse = 1;
      end else m_pulse = 0;
    end
  end

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    #(CLK_P/4);
    if (!done) begin
      bit exp_mod;
      exp_mod = m_armed && (m_pos < 65 * (m_n % 64));
      if (!rst_n) begin
        check_eq("R1 pulse", int'(div_pulse), 0);
        check_eq("R1 mod", int'(mod_sel), 0);
      end else begin
        check_eq("R2 pulse", int'(div_pulse), int'(m_pulse));
        check_eq("R3 mod", int'(mod_sel), int'(exp_mod));
      end
      check_eq("R6 bad", int'(ratio_bad), int'((ratio >> 6) < (ratio & 18'h3F)));
    end
  end

  // period measurement
  int cnt = 0, modcnt = 0, last_int = 0, last_mod = 0;
  always @(negedge clk) begin
    if (div_pulse) begin
      last_int = cnt; last_mod = modcnt; cnt = 0; modcnt = 0;
    end
    cnt++;
    if (mod_sel) modcnt++;
  end

  task automatic wait_pulse();
    forever begin
      @(negedge clk); #1;
      if (div_pulse) break;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rel;
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    // R9 first pulse after reset arming: N+1 negedges from release
    rel = 0;
    forever begin
      @(negedge clk); rel++; #1;
      if (div_pulse) break;
    end
    check_eq("R9 first pulse", rel, 10001);
    wait_pulse();
    check_eq("R4 interval", last_int, 10000);
    check_eq("R4 mod window (A=16)", last_mod, 1040);
    // R7 mid-period change
    repeat (3000) @(negedge clk);
    #1 ratio = 18'd4159;
    wait_pulse();
    check_eq("R7 old period kept", last_int, 10000);
    wait_pulse();
    check_eq("R7 new period", last_int, 4159);
    check_eq("R3 mod window (A=63)", last_mod, 4095);
    ratio = 18'd4095;
    wait_pulse();
    wait_pulse();
    check_eq("R3 B equals A interval", last_int, 4095);
    check_eq("R3 B equals A mod", last_mod, 4095);
    ratio = 18'd4032;
    wait_pulse();
    wait_pulse();
    check_eq("R5 min interval", last_int, 4032);
    check_eq("R3 A zero mod", last_mod, 0);
    // R8 standby mid-period
    repeat (1000) @(negedge clk);
    #1 standby = 1'b1;
    repeat (10) @(negedge clk);
    #1 check_eq("R8 pulse low", int'(div_pulse), 0);
    check_eq("R8 mod low", int'(mod_sel), 0);
    ratio = 18'h0003F;
    #1 check_eq("R6 bad set", int'(ratio_bad), 1);
    ratio = 18'd20031;
    #1 check_eq("R6 bad clear", int'(ratio_bad), 0);
    repeat (10) @(negedge clk);
    #1 standby = 1'b0;
    rel = 0;
    forever begin
      @(negedge clk); rel++; #1;
      if (div_pulse) break;
    end
    check_eq("R8 restart", rel, 20032);
    wait_pulse();
    check_eq("R2 large interval", last_int, 20031);
    check_eq("R3 large mod", last_mod, 4095);
    finish_run();
  end
endmodule